// File: doc/BRIEF.md
# Overlapped Scan Pattern Sequencer

This block applies a series of test patterns to one or more equal-length scan chains that live outside it. It drives the scan-enable, the serial data into each chain and a clock enable that tells the chains when to advance. Patterns arrive on a ready/valid stimulus stream. Responses leave on a ready/valid response stream and are also compared on the fly against expected bits that travel in the same stimulus word. Loading the next pattern and unloading the previous response share the same shift cycles. For L-bit chains and N patterns, a slow single-capture run therefore takes N*(L+1)+L cycles and not N*(2L+1).

Three capture styles are offered. The first is a slow single capture for static faults. The second is a broadside style for transition faults, with two functional cycles back to back: one to launch and one to capture. The third is a skewed-load style for transition faults, where the final load shift is itself the launch and a single capture follows at once. An at-speed marker tells the clock controller which cycles must run at the functional rate. Shifting stalls cleanly whenever a stream partner is not ready.

Top module: `scan_apply_seq`

## Requirements
- R1: While rst_ni is low and after it rises, busy_o, scan_en_o, clk_en_o, at_speed_o, done_o, fail_o, stim_ready_o and resp_valid_o are all 0.
- R2: A start_i pulse in idle with num_pat_i > 0 begins a run and latches mode_i and num_pat_i. A start with num_pat_i = 0 is ignored. Mode encoding: 0 = slow single capture, 1 = broadside (two captures), 2 = skewed load, 3 = same as 0.
- R3: In mode 0 the run holds scan_en_o high for L shift cycles per load and drops it for exactly one capture cycle per pattern. With no stalls, busy_o lasts N*(L+1)+L cycles.
- R4: In mode 1 each pattern gets two consecutive cycles with scan_en_o low, both with at_speed_o high. With no stalls, busy_o lasts N*(L+2)+L cycles.
- R5: In mode 2 the last load shift of each pattern and the single capture that follows it both carry at_speed_o. With no stalls, busy_o lasts N*(L+1)+L cycles.
- R6: A stimulus word is {expected[C-1:0], stimulus[C-1:0]}, with bit c belonging to chain c. Exactly (N+1)*L words are taken. During a shift, scan_in_o carries the stimulus field. The unload of pattern i shares its shift cycles with the load of pattern i+1.
- R7: During unload shifts, resp_valid_o is high and resp_data_o equals scan_out_i. Any bit that differs from the expected field sets fail_o. fail_o stays set until the next accepted start.
- R8: When stim_valid_i is low, or when an unload is in progress and resp_ready_i is low, a shift cycle does not advance: clk_en_o is 0, scan_en_o stays high and the counters hold.
- R9: done_o is a one-cycle pulse in the cycle after the final unload shift, with busy_o already low.
- R10: Every cycle of a run with scan_en_o low has clk_en_o high. at_speed_o is never high in mode 0 and never high without clk_en_o.
- R11: All C chains shift together, one bit per chain per advancing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (taken in idle only) |
| mode_i | input | 2 | Capture style |
| num_pat_i | input | PAT_W | Number of patterns N |
| stim_valid_i | input | 1 | Stimulus word valid |
| stim_data_i | input | 2*NUM_CHAINS | {expected, stimulus} bits |
| stim_ready_o | output | 1 | Stimulus word taken this cycle if valid |
| scan_en_o | output | 1 | 1 = shift, 0 = functional capture |
| scan_in_o | output | NUM_CHAINS | Serial data into each chain |
| scan_out_i | input | NUM_CHAINS | Serial data out of each chain |
| clk_en_o | output | 1 | Chains advance at the next edge |
| at_speed_o | output | 1 | This cycle must run at functional rate |
| resp_valid_o | output | 1 | Response bits valid |
| resp_data_o | output | NUM_CHAINS | Response bits, one per chain |
| resp_ready_i | input | 1 | Response sink ready |
| fail_o | output | 1 | Sticky mismatch flag |
| done_o | output | 1 | Run finished (one-cycle pulse) |
| busy_o | output | 1 | Run in progress |

## Verification
scan_en_o, scan_in_o, clk_en_o, at_speed_o, stim_ready_o and the response outputs follow the current state and inputs within the same cycle. The bench sets inputs at the falling edge and reads these outputs 1 ns later, before the rising edge that acts on them. fail_o and done_o are registered and appear one cycle after the shift that causes them, so the bench reads them at the end of the run or on the falling edge after that shift. The external chain model takes its new contents at the edge where clk_en_o was seen high, so response bits are predicted from the patterns the bench loaded.

// File: rtl/scan_apply_seq_pkg.sv
package scan_apply_seq_pkg;
  typedef enum logic [1:0] {
    MODE_STUCK = 2'd0,
    MODE_LOC   = 2'd1,
    MODE_LOS   = 2'd2
  } cap_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_CAPT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/scan_seq_ctrl.sv
module scan_seq_ctrl
  import scan_apply_seq_pkg::*;
#(
  parameter int CHAIN_LEN = 8,
  parameter int PAT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [PAT_W-1:0] num_pat_i,
  input  logic             stim_valid_i,
  input  logic             resp_ready_i,
  output logic             start_ok_o,
  output logic             step_o,
  output logic             unload_o,
  output logic             scan_en_o,
  output logic             clk_en_o,
  output logic             at_speed_o,
  output logic             stim_ready_o,
  output logic             busy_o,
  output logic             done_o,
  output cap_mode_e        mode_o
);
  localparam int BIT_W = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAIN_LEN - 1);

  seq_state_e       state_q;
  cap_mode_e        mode_q;
  logic [PAT_W-1:0] pat_left_q;
  logic [BIT_W-1:0] bit_q;
  logic             loading_q, unloading_q, second_q, done_q;
  logic             shift_ok, step, last_bit;

  assign shift_ok   = (state_q == ST_SHIFT) && (!unloading_q || resp_ready_i);
  assign step       = shift_ok && stim_valid_i;
  assign last_bit   = (bit_q == LAST_BIT);
  assign start_ok_o = (state_q == ST_IDLE) && start_i && (num_pat_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      mode_q      <= MODE_STUCK;
      pat_left_q  <= '0;
      bit_q       <= '0;
      loading_q   <= 1'b0;
      unloading_q <= 1'b0;
      second_q    <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_ok_o) begin
          state_q     <= ST_SHIFT;
          mode_q      <= (mode_i == MODE_LOC || mode_i == MODE_LOS) ? cap_mode_e'(mode_i) : MODE_STUCK;
          pat_left_q  <= num_pat_i;
          bit_q       <= '0;
          loading_q   <= 1'b1;
          unloading_q <= 1'b0;
        end
        ST_SHIFT: if (step) begin
          if (last_bit) begin
            bit_q <= '0;
            if (loading_q) begin
              state_q    <= ST_CAPT;
              second_q   <= 1'b0;
              pat_left_q <= pat_left_q - 1'b1;
            end else begin
              state_q     <= ST_IDLE;
              unloading_q <= 1'b0;
              done_q      <= 1'b1;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        ST_CAPT: begin
          if (mode_q == MODE_LOC && !second_q) begin
            second_q <= 1'b1;
          end else begin
            state_q     <= ST_SHIFT;
            unloading_q <= 1'b1;
            loading_q   <= (pat_left_q != '0);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign step_o       = step;
  assign unload_o     = (state_q == ST_SHIFT) && unloading_q;
  assign scan_en_o    = (state_q == ST_SHIFT);
  assign clk_en_o     = step || (state_q == ST_CAPT);
  // skewed-load: final load shift is the launch
  assign at_speed_o   = ((state_q == ST_CAPT) && (mode_q != MODE_STUCK)) ||
                        (step && (mode_q == MODE_LOS) && loading_q && last_bit);
  assign stim_ready_o = shift_ok;
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign mode_o       = mode_q;
endmodule

// File: rtl/scan_resp_cmp.sv
module scan_resp_cmp #(
  parameter int NUM_CHAINS = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clear_i,
  input  logic                  check_i,
  input  logic [NUM_CHAINS-1:0] scan_out_i,
  input  logic [NUM_CHAINS-1:0] exp_i,
  output logic                  fail_o
);
  logic [NUM_CHAINS-1:0] mism;
  logic                  fail_q;

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    assign mism[c] = scan_out_i[c] ^ exp_i[c];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               fail_q <= 1'b0;
    else if (clear_i)          fail_q <= 1'b0;
    else if (check_i && |mism) fail_q <= 1'b1;
  end

  assign fail_o = fail_q;
endmodule

// File: rtl/scan_apply_seq.sv
module scan_apply_seq
  import scan_apply_seq_pkg::*;
#(
  parameter int NUM_CHAINS = 2,
  parameter int CHAIN_LEN  = 8,
  parameter int PAT_W      = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [1:0]              mode_i,
  input  logic [PAT_W-1:0]        num_pat_i,
  input  logic                    stim_valid_i,
  input  logic [2*NUM_CHAINS-1:0] stim_data_i,
  output logic                    stim_ready_o,
  output logic                    scan_en_o,
  output logic [NUM_CHAINS-1:0]   scan_in_o,
  input  logic [NUM_CHAINS-1:0]   scan_out_i,
  output logic                    clk_en_o,
  output logic                    at_speed_o,
  output logic                    resp_valid_o,
  output logic [NUM_CHAINS-1:0]   resp_data_o,
  input  logic                    resp_ready_i,
  output logic                    fail_o,
  output logic                    done_o,
  output logic                    busy_o
);
  logic      start_ok, step, unload;
  cap_mode_e cur_mode;

  scan_seq_ctrl #(
    .CHAIN_LEN(CHAIN_LEN),
    .PAT_W    (PAT_W)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .num_pat_i   (num_pat_i),
    .stim_valid_i(stim_valid_i),
    .resp_ready_i(resp_ready_i),
    .start_ok_o  (start_ok),
    .step_o      (step),
    .unload_o    (unload),
    .scan_en_o   (scan_en_o),
    .clk_en_o    (clk_en_o),
    .at_speed_o  (at_speed_o),
    .stim_ready_o(stim_ready_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .mode_o      (cur_mode)
  );

  scan_resp_cmp #(
    .NUM_CHAINS(NUM_CHAINS)
  ) u_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_ok),
    .check_i   (step && unload),
    .scan_out_i(scan_out_i),
    .exp_i     (stim_data_i[2*NUM_CHAINS-1:NUM_CHAINS]),
    .fail_o    (fail_o)
  );

  assign scan_in_o    = scan_en_o ? stim_data_i[NUM_CHAINS-1:0] : '0;
  assign resp_valid_o = unload && stim_valid_i;
  assign resp_data_o  = scan_out_i;
endmodule

// File: rtl/scan_apply_seq_chk.sv
module scan_apply_seq_chk
  import scan_apply_seq_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input logic      start_i,
  input logic      stim_valid_i,
  input logic      scan_en_o,
  input logic      clk_en_o,
  input logic      at_speed_o,
  input logic      resp_valid_o,
  input logic      fail_o,
  input logic      done_o,
  input logic      busy_o,
  input cap_mode_e cur_mode
);
  assert_capture_clocked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !scan_en_o |-> clk_en_o);
  assert_stuck_slow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && cur_mode == MODE_STUCK |-> !at_speed_o);
  assert_speed_clocked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_speed_o |-> clk_en_o);
  assert_single_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scan_en_o) && busy_o && cur_mode != MODE_LOC |=> scan_en_o);
  assert_double_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scan_en_o) && busy_o && cur_mode == MODE_LOC |=> !scan_en_o ##1 scan_en_o);
  assert_stall_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o && !stim_valid_i |-> !clk_en_o);
  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o && !stim_valid_i |=> scan_en_o);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_fail_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o);
  assert_resp_in_shift_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> scan_en_o);
endmodule

bind scan_apply_seq scan_apply_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .stim_valid_i(stim_valid_i),
  .scan_en_o   (scan_en_o),
  .clk_en_o    (clk_en_o),
  .at_speed_o  (at_speed_o),
  .resp_valid_o(resp_valid_o),
  .fail_o      (fail_o),
  .done_o      (done_o),
  .busy_o      (busy_o),
  .cur_mode    (cur_mode)
);

// File: tb/sim_scan_apply_seq.sv
`timescale 1ns/1ps
module sim_scan_apply_seq;
  localparam int C     = 2;
  localparam int L     = 5;
  localparam int PW    = 8;
  localparam int NROWS = 7;
  // per row: mode, patterns, stall kind (0 none, 1 valid gap, 2 resp_ready gap), fault, base cycles, at-speed, captures
  localparam int ROW_MODE [NROWS] = '{0, 1, 2, 0, 1, 3, 0};
  localparam int ROW_N    [NROWS] = '{3, 2, 4, 1, 3, 2, 2};
  localparam int ROW_STL  [NROWS] = '{0, 0, 0, 1, 0, 0, 2};
  localparam int ROW_FLT  [NROWS] = '{0, 0, 0, 0, 1, 0, 0};
  localparam int ROW_CYC  [NROWS] = '{23, 19, 29, 11, 26, 17, 17};
  localparam int ROW_SPD  [NROWS] = '{0, 4, 8, 0, 6, 0, 0};
  localparam int ROW_CAP  [NROWS] = '{3, 4, 4, 1, 6, 2, 2};

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    mode_i = '0;
  logic [PW-1:0] num_pat_i = '0;
  logic          stim_valid_i = 1'b0;
  logic [2*C-1:0] stim_data_i = '0;
  logic          resp_ready_i = 1'b1;
  logic          stim_ready_o, scan_en_o, clk_en_o, at_speed_o, resp_valid_o;
  logic          fail_o, done_o, busy_o;
  logic [C-1:0]  scan_in_o, scan_out_i, resp_data_o;
  logic [L-1:0]  chain [C];

  int checks = 0;
  int errors = 0;
  int cyc_total = 0;

  always #10 clk_i = ~clk_i;

  scan_apply_seq #(.NUM_CHAINS(C), .CHAIN_LEN(L), .PAT_W(PW)) u0 (.*);

  // external chains; capture inverts every cell
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < C; c++) chain[c] <= '0;
    end else if (clk_en_o) begin
      for (int c = 0; c < C; c++)
        chain[c] <= scan_en_o ? {chain[c][L-2:0], scan_in_o[c]} : ~chain[c];
    end
  end
  always_comb for (int c = 0; c < C; c++) scan_out_i[c] = chain[c][L-1];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [L-1:0] pat(input int p, input int c, input int row);
    return L'((p * 7 + c * 11 + row * 5 + 3) * 13);
  endfunction

  // response bit k of pattern p: inverted once per capture
  function automatic logic resp_bit(input int p, input int c, input int k, input int row);
    logic b;
    b = pat(p, c, row)[k];
    return (ROW_MODE[row] == 1) ? b : ~b;
  endfunction

  always @(posedge clk_i) begin
    cyc_total++;
    if (cyc_total > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_total, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_row(input int row);
    int n, words, cyc, spd, cap, stalls, stall_bad, resp_bad, dones, guard, p, k;
    bit first, stalled_word;
    logic [C-1:0] st, ex, er;
    n = ROW_N[row];
    words = 0; cyc = 0; spd = 0; cap = 0; stalls = 0; stall_bad = 0;
    resp_bad = 0; dones = 0; guard = 0; first = 1; stalled_word = 0;
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 2'(ROW_MODE[row]); num_pat_i = PW'(n);
    @(negedge clk_i);
    start_i = 1'b0; mode_i = 2'd3; num_pat_i = '0;
    while (dones == 0 && guard < 400) begin
      guard++;
      if (!first) @(negedge clk_i);
      p = words / L; k = words % L;
      for (int c = 0; c < C; c++) begin
        st[c] = (p < n) ? pat(p, c, row)[k] : 1'b0;
        ex[c] = (p >= 1) ? resp_bit(p - 1, c, k, row) : 1'b0;
      end
      er = ex;
      if (ROW_FLT[row] != 0 && words == L + 2) ex[0] = ~ex[0];
      stim_data_i = {ex, st}; stim_valid_i = 1'b1; resp_ready_i = 1'b1;
      #1;
      if (first) begin
        chk(fail_o == 1'b0, "R7 fail cleared by start", fail_o, 0);
        first = 0;
      end
      if (stim_ready_o && !stalled_word && (k % 2 == 1) &&
          ((ROW_STL[row] == 1) || (ROW_STL[row] == 2 && p >= 1))) begin
        if (ROW_STL[row] == 1) stim_valid_i = 1'b0; else resp_ready_i = 1'b0;
        stalls++; stalled_word = 1;
        #1;
        if (clk_en_o !== 1'b0 || scan_en_o !== 1'b1) stall_bad++;
      end
      #1;
      if (busy_o) cyc++;
      if (at_speed_o && clk_en_o) spd++;
      if (busy_o && !scan_en_o) cap++;
      if (resp_valid_o && resp_ready_i && stim_ready_o && resp_data_o !== er) resp_bad++;
      if (scan_en_o && scan_in_o !== st) resp_bad++;
      if (stim_ready_o && stim_valid_i) begin
        words++; stalled_word = 0;
      end
      if (done_o) dones++;
    end
    chk(cyc == ROW_CYC[row] + stalls, $sformatf("R3 R4 R5 cycle total row%0d", row), cyc, ROW_CYC[row] + stalls);
    chk(spd == ROW_SPD[row], $sformatf("R4 R5 R10 at-speed cycles row%0d", row), spd, ROW_SPD[row]);
    chk(cap == ROW_CAP[row], $sformatf("R3 R4 capture cycles row%0d", row), cap, ROW_CAP[row]);
    chk(words == (n + 1) * L, $sformatf("R6 words taken row%0d", row), words, (n + 1) * L);
    chk(resp_bad == 0, $sformatf("R6 R7 R11 response bits row%0d", row), resp_bad, 0);
    chk(dones == 1 && !busy_o, $sformatf("R9 done pulse row%0d", row), dones, 1);
    chk(fail_o == ROW_FLT[row][0], $sformatf("R7 fail flag row%0d", row), fail_o, ROW_FLT[row]);
    if (ROW_STL[row] != 0) begin
      chk(stalls > 0, $sformatf("R8 stalls applied row%0d", row), stalls, 1);
      chk(stall_bad == 0, $sformatf("R8 stall holds row%0d", row), stall_bad, 0);
    end
    stim_valid_i = 1'b0; resp_ready_i = 1'b1;
  endtask

  initial begin
    #5;
    chk({busy_o, scan_en_o, clk_en_o, at_speed_o, done_o, fail_o, stim_ready_o, resp_valid_o} == '0,
        "R1 outputs in reset", busy_o, 0);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({busy_o, scan_en_o, clk_en_o, done_o, fail_o} == '0, "R1 idle after reset", busy_o, 0);

    // start with zero patterns is ignored
    start_i = 1'b1; num_pat_i = '0; mode_i = 2'd1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    chk(busy_o == 1'b0 && scan_en_o == 1'b0, "R2 zero-pattern start ignored", busy_o, 0);

    for (int r = 0; r < NROWS; r++) begin
      run_row(r);
      if (ROW_FLT[r] != 0) begin
        repeat (3) @(negedge clk_i);
        chk(fail_o == 1'b1, "R7 fail sticky in idle", fail_o, 1);
      end
    end

    repeat (2) @(negedge clk_i);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R9 done stays low after run", done_o, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule